// File: doc/BRIEF.md
# Preamble-Regenerating Elasticity Buffer

This block sits in the shared data path of a multiport repeater. Decoded NRZ bits arrive from the receiving segment with their own clock and an activity enable. As soon as activity is seen, the block starts driving a fresh alternating preamble onto the transmit side. Meanwhile it watches the incoming stream for the start-of-frame delimiter and stores none of the received preamble.

Once the delimiter has been found, every following received bit is written into a small bit-wide FIFO in the receive clock domain. The transmit side runs on the local clock. It sends a full-length preamble and then a complete delimiter byte, and only after that does it begin draining the FIFO. When receive activity ends, the buffer empties its remaining bits and then drops transmit enable. The read and write pointers cross between the two clock domains in Gray code.

Collisions between the pointers are reported. If the receive side finds the buffer full, it raises an overflow flag. If the transmit side finds the buffer empty while the frame is still active, it raises an underflow flag.

Top module: `pre_regen_ebuf`

## Requirements
- R1: After reset, `tx_en`, `ovf_flag` and `udf_flag` are all 0.
- R2: After receive activity starts, the first PRE_BITS bits transmitted (default 56) alternate, starting with 1.
- R3: Right after the preamble, the eight bits 1,0,1,0,1,0,1,1 are transmitted in that order.
- R4: The delimiter is detected as a received 1 whose two preceding received bits were 0 then 1, within one activity period. No bit up to and including that 1 is stored. A leading "11" that is not preceded by a 0 does not count.
- R5: The received bits after the delimiter are transmitted in order and unchanged.
- R6: The first stored bit appears at transmit position PRE_BITS+8, and never earlier.
- R7: After `rx_en` falls, all stored bits are sent and then `tx_en` returns to 0. A normal frame therefore lasts exactly PRE_BITS+8+N transmit cycles, where N is the number of stored bits.
- R8: A frame with no delimiter produces only the preamble and the delimiter byte (PRE_BITS+8 bits), and it does not raise `udf_flag`.
- R9: A bit that arrives while the buffer holds DEPTH bits (default 32) is dropped and sets `ovf_flag`. The flag stays set until the next rising edge of `rx_en`.
- R10: If the transmit side needs a data bit while the buffer is empty and receive activity is still present, it sends 0 with `tx_en` high and sets `udf_flag`. The flag stays set until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Local transmit clock |
| tx_rst_n | input | 1 | Synchronous active-low reset, transmit domain |
| rx_clk | input | 1 | Recovered receive clock |
| rx_rst_n | input | 1 | Synchronous active-low reset, receive domain |
| rx_en | input | 1 | Receive activity enable |
| rx_dat | input | 1 | Decoded NRZ receive bit |
| tx_en | output | 1 | Transmit bit valid |
| tx_dat | output | 1 | Transmit bit |
| ovf_flag | output | 1 | Overflow seen in this frame (receive domain) |
| udf_flag | output | 1 | Underflow seen in this frame (transmit domain) |

## Verification
The bench goes after the delimiter-detection corner cases. One frame opens with a stray "11" that a naive pair detector would take as the delimiter; such a detector would shift every data bit and corrupt the stream. A frame with no delimiter at all catches a design that stalls or reports underflow instead of ending after the regenerated header.

Two further corner cases are forced on purpose. A very short received preamble fills the buffer before readout is allowed. A very long one starves readout. A design that gated readout wrongly or cleared its flags at the wrong time would show a wrong header length, a missing or sticky flag, or data bits misplaced relative to position PRE_BITS+8.

// File: rtl/pre_ebuf_pkg.sv
// Shared types and constants for the preamble-regenerating elasticity buffer.
package pre_ebuf_pkg;
    typedef enum logic [1:0] {
        TX_IDLE,
        TX_PRE,
        TX_SFD,
        TX_DATA
    } tx_state_t;

    // Delimiter byte sent after the regenerated preamble; bit 7 goes out first.
    localparam logic [7:0] SFD_PATTERN = 8'b1010_1011;
endpackage

// File: rtl/ebuf_sync.sv
// Two-flop synchronizer for a Gray-coded pointer or a level.
// Assumes the source changes at most one bit per source clock.
module ebuf_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Move the value through two destination-clock flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ebuf_wr.sv
// Receive-domain side: delimiter hunt, bit storage, write pointer and overflow flag.
// Assumes DEPTH is a power of two and rgray_s is already synchronized to rx_clk.
module ebuf_wr #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             rx_dat,
    input  logic [AW:0]      rgray_s,
    output logic [DEPTH-1:0] mem,
    output logic [AW:0]      wgray,
    output logic [AW:0]      wbin,
    output logic             act,
    output logic             storing,
    output logic             full,
    output logic             ovf
);
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    logic [1:0]  hist;
    logic [1:0]  hcnt;
    logic [AW:0] rbin_s;
    logic [AW:0] wbin_nxt;
    logic        sfd_hit;
    logic        wr_go;

    // Convert the synchronized read pointer back to binary.
    always_comb begin
        rbin_s[AW] = rgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    end

    // Occupancy test, delimiter match and write strobe.
    always_comb begin
        full     = (wbin - rbin_s) == FULL_LVL;
        sfd_hit  = rx_en && !storing && (hcnt == 2'd2) && (hist == 2'b01) && rx_dat;
        wr_go    = rx_en && storing && !full;
        wbin_nxt = wbin + (AW+1)'(wr_go);
    end

    // Register receive activity for the transmit side and for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act <= 1'b0;
        else        act <= rx_en;
    end

    // Track the last two received bits and enter storing on a delimiter.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            hist    <= 2'b00;
            hcnt    <= 2'd0;
            storing <= 1'b0;
        end else if (!storing) begin
            hist <= {hist[0], rx_dat};
            if (hcnt != 2'd2) hcnt <= hcnt + 2'd1;
            if (sfd_hit) storing <= 1'b1;
        end
    end

    // Store one data bit per receive clock.
    always_ff @(posedge clk) begin
        if (wr_go) mem[wbin[AW-1:0]] <= rx_dat;
    end

    // Advance the write pointer and publish its Gray form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    // Overflow flag: cleared when activity starts, set on a write into a full buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ovf <= 1'b0;
        else if (rx_en && !act)       ovf <= 1'b0;
        else if (rx_en && storing && full) ovf <= 1'b1;
    end
endmodule

// File: rtl/ebuf_rd.sv
// Transmit-domain side: preamble and delimiter generator, gated readout,
// read pointer and underflow flag. Assumes wgray_s and act_s are synchronized.
module ebuf_rd
    import pre_ebuf_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int AW       = $clog2(DEPTH),
    parameter int PRE_BITS = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_s,
    input  logic [AW:0]      wgray_s,
    input  logic [DEPTH-1:0] mem,
    output logic [AW:0]      rgray,
    output logic             tx_en,
    output logic             tx_dat,
    output logic             in_pre,
    output logic             udf
);
    localparam int CW = ($clog2(PRE_BITS) < 3) ? 3 : $clog2(PRE_BITS);
    localparam logic [CW-1:0] PRE_LAST = CW'(PRE_BITS - 1);

    tx_state_t   state, nstate;
    logic [CW-1:0] cnt;
    logic [AW:0] rbin, rbin_nxt, wbin_s;
    logic        empty;
    logic        rd_go;
    logic        underrun;

    // Convert the synchronized write pointer back to binary.
    always_comb begin
        wbin_s[AW] = wgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    end

    // Output selection and next state for the transmit sequencer.
    always_comb begin
        empty    = (rbin == wbin_s);
        nstate   = state;
        tx_en    = 1'b0;
        tx_dat   = 1'b0;
        rd_go    = 1'b0;
        underrun = 1'b0;
        case (state)
            TX_IDLE: if (act_s) nstate = TX_PRE;
            TX_PRE: begin
                tx_en  = 1'b1;
                tx_dat = ~cnt[0];
                if (cnt == PRE_LAST) nstate = TX_SFD;
            end
            TX_SFD: begin
                tx_en  = 1'b1;
                tx_dat = SFD_PATTERN[~cnt[2:0]];
                if (cnt[2:0] == 3'd7) nstate = TX_DATA;
            end
            default: begin
                if (!empty) begin
                    tx_en  = 1'b1;
                    tx_dat = mem[rbin[AW-1:0]];
                    rd_go  = 1'b1;
                end else if (act_s) begin
                    tx_en    = 1'b1;
                    underrun = 1'b1;
                end else begin
                    nstate = TX_IDLE;
                end
            end
        endcase
        rbin_nxt = rbin + (AW+1)'(rd_go);
        in_pre   = (state == TX_PRE);
    end

    // State and bit counter; the counter restarts on every state change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
        end else begin
            state <= nstate;
            cnt   <= (nstate != state) ? '0 : cnt + 1'b1;
        end
    end

    // Advance the read pointer and publish its Gray form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    // Underflow flag: cleared at frame start, set on a read from an empty active buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)                      udf <= 1'b0;
        else if (state == TX_IDLE && act_s) udf <= 1'b0;
        else if (underrun)               udf <= 1'b1;
    end
endmodule

// File: rtl/pre_regen_ebuf.sv
// Top level: joins the receive-side writer and the transmit-side reader
// through Gray pointer synchronizers. Assumes both resets are applied together.
module pre_regen_ebuf #(
    parameter int DEPTH    = 32,
    parameter int PRE_BITS = 56
) (
    input  logic tx_clk,
    input  logic tx_rst_n,
    input  logic rx_clk,
    input  logic rx_rst_n,
    input  logic rx_en,
    input  logic rx_dat,
    output logic tx_en,
    output logic tx_dat,
    output logic ovf_flag,
    output logic udf_flag
);
    localparam int AW = $clog2(DEPTH);

    logic [DEPTH-1:0] mem;
    logic [AW:0]      wgray, wgray_s, rgray, rgray_s, wbin;
    logic             act, act_s, storing, full, in_pre;

    ebuf_wr #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .clk(rx_clk), .rst_n(rx_rst_n), .rx_en(rx_en), .rx_dat(rx_dat),
        .rgray_s(rgray_s), .mem(mem), .wgray(wgray), .wbin(wbin), .act(act),
        .storing(storing), .full(full), .ovf(ovf_flag)
    );

    ebuf_sync #(.W(AW + 1)) u_rsync (
        .clk(rx_clk), .rst_n(rx_rst_n), .d(rgray), .q(rgray_s)
    );

    ebuf_sync #(.W(AW + 1)) u_wsync (
        .clk(tx_clk), .rst_n(tx_rst_n), .d(wgray), .q(wgray_s)
    );

    ebuf_sync #(.W(1)) u_async (
        .clk(tx_clk), .rst_n(tx_rst_n), .d(act), .q(act_s)
    );

    ebuf_rd #(.DEPTH(DEPTH), .AW(AW), .PRE_BITS(PRE_BITS)) u_rd (
        .clk(tx_clk), .rst_n(tx_rst_n), .act_s(act_s), .wgray_s(wgray_s),
        .mem(mem), .rgray(rgray), .tx_en(tx_en), .tx_dat(tx_dat),
        .in_pre(in_pre), .udf(udf_flag)
    );
endmodule

// File: rtl/pre_regen_ebuf_chk.sv
// Property checker for pre_regen_ebuf, attached by bind. Watches both clock domains.
module pre_regen_ebuf_chk #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic        tx_clk,
    input logic        tx_rst_n,
    input logic        rx_clk,
    input logic        rx_rst_n,
    input logic        tx_en,
    input logic        tx_dat,
    input logic        udf_flag,
    input logic        ovf_flag,
    input logic        in_pre,
    input logic        storing,
    input logic        full,
    input logic [AW:0] wbin,
    input logic [AW:0] rgray_s
);
    logic [AW:0] rbin_s;
    logic [AW:0] level;

    // Occupancy as seen by the receive side.
    always_comb begin
        rbin_s[AW] = rgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
        level = wbin - rbin_s;
    end

    // R2
    pre_start_one_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        $rose(tx_en) |-> tx_dat);

    // R2
    pre_alternate_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        (in_pre && $past(in_pre)) |-> (tx_dat != $past(tx_dat)));

    // R4
    no_early_write_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        (wbin != $past(wbin)) |-> $past(storing));

    // R9
    no_overflow_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        level <= (AW+1)'(DEPTH));

    // R9
    ovf_when_full_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        $rose(ovf_flag) |-> $past(full));

    // R10
    udf_while_sending_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        $rose(udf_flag) |-> $past(tx_en));
endmodule

bind pre_regen_ebuf pre_regen_ebuf_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
    .tx_en(tx_en), .tx_dat(tx_dat), .udf_flag(udf_flag), .ovf_flag(ovf_flag),
    .in_pre(in_pre), .storing(storing), .full(full), .wbin(wbin), .rgray_s(rgray_s)
);

// File: tb/pre_regen_ebuf_bench.sv
// Bench: directed corner frames plus seeded random frames; expected streams built here.
module pre_regen_ebuf_bench;
    localparam int DEPTH    = 32;
    localparam int PRE_BITS = 56;
    localparam int HDR      = PRE_BITS + 8;

    logic tx_clk = 1'b0, rx_clk = 1'b0;
    logic tx_rst_n = 1'b0, rx_rst_n = 1'b0;
    logic rx_en = 1'b0, rx_dat = 1'b0;
    logic tx_en, tx_dat, ovf_flag, udf_flag;

    int errors = 0;
    int checks = 0;
    int ncap   = 0;
    logic cap   [0:1023];
    logic rxb   [0:511];
    logic expd  [0:255];
    int   nrx;
    int   ndat;

    pre_regen_ebuf #(.DEPTH(DEPTH), .PRE_BITS(PRE_BITS)) u_pre_regen_ebuf (
        .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
        .rx_en(rx_en), .rx_dat(rx_dat), .tx_en(tx_en), .tx_dat(tx_dat),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    initial forever #10 tx_clk = ~tx_clk;
    initial begin
        #7;
        forever #10 rx_clk = ~rx_clk;
    end

    // Record every transmitted bit.
    always @(negedge tx_clk) begin
        if (tx_rst_n && tx_en) begin
            if (ncap < 1024) cap[ncap] = tx_dat;
            ncap = ncap + 1;
        end
    end

    function automatic logic pre_bit(input int i);
        return (i % 2 == 0) ? 1'b1 : 1'b0;
    endfunction

    function automatic logic sfd_bit(input int i);
        return (i == 7) ? 1'b1 : ((i % 2 == 0) ? 1'b1 : 1'b0);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Build a received stream: optional stray "11", alternating preamble, optional delimiter, data.
    task automatic build(input bit stray, input int p, input bit with_sfd, input int n);
        nrx  = 0;
        ndat = 0;
        if (stray) begin
            rxb[nrx++] = 1'b1;
            rxb[nrx++] = 1'b1;
        end
        for (int i = 0; i < p; i++) rxb[nrx++] = pre_bit(i);
        if (with_sfd) begin
            rxb[nrx++] = 1'b1;
            rxb[nrx++] = 1'b1;
            for (int i = 0; i < n; i++) begin
                expd[ndat] = 1'($urandom % 2);
                rxb[nrx++] = expd[ndat];
                ndat++;
            end
        end
    endtask

    task automatic send;
        ncap = 0;
        for (int i = 0; i < nrx; i++) begin
            @(negedge rx_clk);
            rx_en  = 1'b1;
            rx_dat = rxb[i];
        end
        @(negedge rx_clk);
        rx_en  = 1'b0;
        rx_dat = 1'b0;
        repeat (150) @(posedge tx_clk);
        @(negedge tx_clk);
    endtask

    // Compare the captured header and, optionally, length and data.
    task automatic check_frame(input bit do_len, input bit do_data);
        int bad;
        chk(tx_en == 1'b0, "R7", "tx_en after drain", int'(tx_en), 0);
        bad = 0;
        for (int i = 0; i < PRE_BITS; i++) if (cap[i] !== pre_bit(i)) bad++;
        chk(bad == 0, "R2", "preamble bit errors", bad, 0);
        bad = 0;
        for (int i = 0; i < 8; i++) if (cap[PRE_BITS + i] !== sfd_bit(i)) bad++;
        chk(bad == 0, "R3", "delimiter bit errors", bad, 0);
        if (do_len) chk(ncap == HDR + ndat, "R7", "frame length", ncap, HDR + ndat);
        if (do_data && ndat > 0) begin
            chk(cap[HDR] === expd[0], "R6", "first data bit position", int'(cap[HDR]), int'(expd[0]));
            bad = 0;
            for (int i = 0; i < ndat; i++) if (cap[HDR + i] !== expd[i]) bad++;
            chk(bad == 0, "R5", "data bit errors", bad, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(posedge tx_clk);
        @(negedge tx_clk);
        chk(tx_en == 1'b0, "R1", "tx_en in reset", int'(tx_en), 0);
        tx_rst_n = 1'b1;
        rx_rst_n = 1'b1;
        repeat (4) @(posedge tx_clk);
        @(negedge tx_clk);
        chk(tx_en == 1'b0, "R1", "tx_en after reset", int'(tx_en), 0);
        chk(ovf_flag == 1'b0, "R1", "ovf_flag after reset", int'(ovf_flag), 0);
        chk(udf_flag == 1'b0, "R1", "udf_flag after reset", int'(udf_flag), 0);

        // R4: stray leading "11" must not be taken as the delimiter.
        build(1'b1, 40, 1'b1, 64);
        send();
        check_frame(1'b1, 1'b1);

        // Random frames: preamble 38..44 bits, 20..150 data bits.
        for (int f = 0; f < 6; f++) begin
            build(1'b0, 38 + 2 * int'($urandom % 4), 1'b1, 20 + int'($urandom % 131));
            send();
            check_frame(1'b1, 1'b1);
            chk(ovf_flag == 1'b0 && udf_flag == 1'b0, "R5", "flags on normal frame",
                int'({ovf_flag, udf_flag}), 0);
        end

        // R8: no delimiter at all.
        build(1'b0, 50, 1'b0, 0);
        send();
        check_frame(1'b1, 1'b0);
        chk(udf_flag == 1'b0, "R8", "udf on frame without delimiter", int'(udf_flag), 0);

        // R9: short received preamble overfills the buffer.
        build(1'b0, 8, 1'b1, 60);
        send();
        check_frame(1'b0, 1'b0);
        chk(ovf_flag == 1'b1, "R9", "ovf_flag after overfill", int'(ovf_flag), 1);
        build(1'b0, 40, 1'b1, 40);
        send();
        check_frame(1'b1, 1'b1);
        chk(ovf_flag == 1'b0, "R9", "ovf_flag cleared next frame", int'(ovf_flag), 0);

        // R10: long received preamble starves readout.
        build(1'b0, 80, 1'b1, 20);
        send();
        check_frame(1'b0, 1'b0);
        chk(udf_flag == 1'b1, "R10", "udf_flag after starvation", int'(udf_flag), 1);
        chk(cap[HDR] === 1'b0, "R10", "filler bit value", int'(cap[HDR]), 0);
        build(1'b0, 42, 1'b1, 30);
        send();
        check_frame(1'b1, 1'b1);
        chk(udf_flag == 1'b0, "R10", "udf_flag cleared next frame", int'(udf_flag), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (150000) @(posedge tx_clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule